// File: doc/BRIEF.md
# Asynchronous FIFO-Slave Burst Read Engine

This block is the master side of a byte-wide link to an external slave FIFO that has no clock of its own. It runs a fixed per-byte waveform that is counted in master clock cycles. The waveform has five steps. First a settle wait. Then a test of the slave's empty flag, and a test of the local buffer's full flag. Then a read strobe pulse together with the output enable. Finally the data is sampled while both strobes are still low. After that the engine loops back and starts the next byte. The waveform never stops by itself.

The slave empty flag comes in asynchronously, so it passes through a synchronizer before the engine tests it. If the engine finds the slave empty, it parks in a pre-abort state and signals this. It stays there until an external abort command releases it. When the local buffer reports full, the engine stalls before the strobe. Each captured byte goes to the local buffer with a one-cycle valid pulse.

Top module: `fifo_burst_reader`

## Requirements
- R1: While `rst_ni` is low, `slrd_n_o` and `sloe_n_o` are 1, `pre_abort_o` is 0 and `byte_vld_o` is 0.
- R2: After reset, after each byte, and after an abort, both strobes stay high for WAIT_CYC (4) cycles of settle wait. A flag-test cycle follows, and then a throttle cycle.
- R3: The engine tests the slave empty flag `empty_n_i` (0 means empty) only after two synchronizer flops. A change in that flag affects the flag test no earlier than the third rising edge after the flag is sampled.
- R4: If the synchronized empty flag reads 0 in the flag-test cycle, the engine enters pre-abort on the next cycle. It then holds `pre_abort_o` at 1 and both strobes at 1 for as long as `abort_i` stays 0.
- R5: When `abort_i` is 1 in a pre-abort cycle, the engine returns to the settle wait on the next cycle, with `pre_abort_o` at 0 and both strobes at 1.
- R6: While `buf_full_n_i` is 0 (local buffer full), the engine holds in the throttle step and issues no strobe. The strobe falls on the cycle after the first throttle cycle in which `buf_full_n_i` is 1.
- R7: `slrd_n_o` and `sloe_n_o` go low together and stay low for STRB_CYC+1 (4) consecutive cycles. These are three strobe cycles and one sample cycle.
- R8: `byte_o` takes the value of `data_i` at the rising edge that ends the last low-strobe cycle. In the cycle that follows, `byte_vld_o` is 1 for exactly one cycle.
- R9: With the slave never empty and the buffer never full, the engine transfers one byte every 11 cycles.
- R10: `abort_i` has no effect outside the pre-abort state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| empty_n_i | input | 1 | Slave empty flag, asynchronous, 0 = empty |
| buf_full_n_i | input | 1 | Local buffer full flag, 0 = full |
| abort_i | input | 1 | Abort command, releases pre-abort |
| data_i | input | DATA_W | Slave data bus |
| slrd_n_o | output | 1 | Read strobe, active low |
| sloe_n_o | output | 1 | Output enable, active low |
| pre_abort_o | output | 1 | Slave found empty, waiting for abort |
| byte_o | output | DATA_W | Last captured byte |
| byte_vld_o | output | 1 | One-cycle pulse per captured byte |

## Verification
Two pairs of functions can coincide. The first pair is a full local buffer and a slave that runs dry. The bench holds the engine in the throttle step and drops the empty flag while it waits there. The model expects the current byte to finish with a full strobe. It also expects the empty flag to be caught only at the next flag test, after the two synchronizer stages. The second pair is abort pulses and normal strobing: the bench issues aborts during strobe cycles, and the model expects them to leave the waveform unchanged. A behavioural per-cycle model judges every cycle of both cases.

// File: rtl/rdeng_pkg.sv
package rdeng_pkg;
  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_TEST  = 3'd1,
    ST_THROT = 3'd2,
    ST_STRB  = 3'd3,
    ST_SAMP  = 3'd4,
    ST_LOOP  = 3'd5,
    ST_PREAB = 3'd6
  } rd_state_e;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
  import rdeng_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 4,
  parameter int STRB_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              empty_n_s_i,
  input  logic              buf_full_n_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              slrd_n_o,
  output logic              sloe_n_o,
  output logic              pre_abort_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o
);
  localparam int MAX_CYC = (WAIT_CYC > STRB_CYC) ? WAIT_CYC : STRB_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STRB_CYC - 1);

  rd_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] byte_q;
  logic vld_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_WAIT: begin
        if (cnt_q == WAIT_LAST) begin
          cnt_d   = '0;
          state_d = ST_TEST;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_TEST:  state_d = empty_n_s_i ? ST_THROT : ST_PREAB;
      ST_THROT: if (buf_full_n_i) state_d = ST_STRB;
      ST_STRB: begin
        if (cnt_q == STRB_LAST) begin
          cnt_d   = '0;
          state_d = ST_SAMP;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_SAMP:  state_d = ST_LOOP;
      ST_LOOP:  state_d = ST_WAIT;
      ST_PREAB: if (abort_i) state_d = ST_WAIT;
      default:  state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      byte_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vld_q   <= (state_q == ST_SAMP);
      if (state_q == ST_SAMP) byte_q <= data_i;
    end
  end

  logic strobing;
  assign strobing    = (state_q == ST_STRB) || (state_q == ST_SAMP);
  assign slrd_n_o    = ~strobing;
  assign sloe_n_o    = ~strobing;
  assign pre_abort_o = (state_q == ST_PREAB);
  assign byte_o      = byte_q;
  assign byte_vld_o  = vld_q;

  a_r6_strobe_needs_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slrd_n_o) |-> $past(buf_full_n_i));
  a_r4_preab_from_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre_abort_o) |-> !$past(empty_n_s_i));
  a_r4_preab_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_abort_o |-> (slrd_n_o && sloe_n_o));
  a_r4_preab_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_abort_o && !abort_i) |=> pre_abort_o);
  a_r5_abort_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_abort_o && abort_i) |=> (!pre_abort_o && slrd_n_o));
  a_r8_vld_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
  a_r8_vld_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> !$past(slrd_n_o));
  a_r7_strobe_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slrd_n_o) |=> !slrd_n_o);
endmodule

// File: rtl/fifo_burst_reader.sv
module fifo_burst_reader #(
  parameter int DATA_W      = 8,
  parameter int WAIT_CYC    = 4,
  parameter int STRB_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              empty_n_i,
  input  logic              buf_full_n_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              slrd_n_o,
  output logic              sloe_n_o,
  output logic              pre_abort_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o
);
  logic empty_n_s;

  flag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_empty_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (empty_n_i),
    .q_o   (empty_n_s)
  );

  burst_fsm #(.DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC), .STRB_CYC(STRB_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .empty_n_s_i (empty_n_s),
    .buf_full_n_i(buf_full_n_i),
    .abort_i     (abort_i),
    .data_i      (data_i),
    .slrd_n_o    (slrd_n_o),
    .sloe_n_o    (sloe_n_o),
    .pre_abort_o (pre_abort_o),
    .byte_o      (byte_o),
    .byte_vld_o  (byte_vld_o)
  );

  a_r7_strobes_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slrd_n_o == sloe_n_o);
endmodule

// File: tb/fifo_burst_reader_bench.sv
`timescale 1ns/1ps
module fifo_burst_reader_bench;
  logic clk = 0, rst_ni = 0;
  logic empty_n = 1, full_n = 1, abort = 0;
  logic [7:0] data = 0;
  logic slrd_n, sloe_n, preab, vld;
  logic [7:0] byte_v;

  always #10 clk = ~clk;

  fifo_burst_reader u_fifo_burst_reader (
    .clk_i(clk), .rst_ni(rst_ni), .empty_n_i(empty_n), .buf_full_n_i(full_n),
    .abort_i(abort), .data_i(data), .slrd_n_o(slrd_n), .sloe_n_o(sloe_n),
    .pre_abort_o(preab), .byte_o(byte_v), .byte_vld_o(vld));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, cmp_en = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // behavioural reference: phase 0..10 per byte, 99 = parked
  int ph = 0;
  bit s1 = 1, s2 = 1, m_vld = 0, after_abort = 0;
  logic [7:0] m_byte = 0;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph = 0; s1 = 1; s2 = 1; m_vld = 0; m_byte = 0; after_abort = 0;
    end else begin
      m_vld = 0;
      if (ph != 0) after_abort = 0;
      case (ph)
        3:  ph = 4;
        4:  ph = s2 ? 5 : 99;
        5:  ph = full_n ? 6 : 5;
        9:  begin m_byte = data; m_vld = 1; ph = 10; end
        10: ph = 0;
        99: if (abort) begin ph = 0; after_abort = 1; end
        default: ph = ph + 1;
      endcase
      s2 = s1; s1 = empty_n;
    end
  end

  always @(negedge clk) begin
    cyc++;
    data <= 8'(cyc * 37 + 5);
    if (cmp_en) begin
      string tag;
      bit exp_strb;
      exp_strb = (ph >= 6 && ph <= 9);
      if (abort && ph != 99)     tag = "R10";
      else if (after_abort)      tag = "R5";
      else if (ph == 4)          tag = "R3";
      else if (ph < 4)           tag = "R2";
      else if (ph == 5)          tag = "R6";
      else if (ph == 99)         tag = "R4";
      else                       tag = "R7";
      chk(slrd_n == !exp_strb && sloe_n == !exp_strb, tag, {slrd_n, sloe_n}, {2{!exp_strb}});
      chk(preab == (ph == 99), tag, preab, ph == 99);
      chk(vld == m_vld, "R8", vld, m_vld);
      chk(byte_v == m_byte, "R8", byte_v, m_byte);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int last_vld, gap, strb_seen;
    wait_cyc(3);
    chk(slrd_n && sloe_n, "R1", {slrd_n, sloe_n}, 3);
    chk(!preab && !vld, "R1", {preab, vld}, 0);
    rst_ni = 1;
    cmp_en = 1;
    // R9: free-running byte period
    last_vld = -1; gap = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (vld) begin
        if (last_vld >= 0) begin gap = cyc - last_vld; chk(gap == 11, "R9", gap, 11); end
        last_vld = cyc;
      end
    end
    // R6: hold buffer full, no strobe allowed
    full_n = 0; wait_cyc(12);
    strb_seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!slrd_n) strb_seen++; end
    chk(strb_seen == 0, "R6", strb_seen, 0);
    // full and empty together: drop empty while throttled, then release
    empty_n = 0; wait_cyc(5);
    full_n = 1; wait_cyc(20);
    chk(preab == 1, "R4", preab, 1);
    wait_cyc(15);
    chk(preab == 1, "R4", preab, 1);
    empty_n = 1;
    abort = 1; @(negedge clk); abort = 0;
    chk(preab == 0 && slrd_n, "R5", {preab, slrd_n}, 1);
    // R10: abort pulses during normal strobing
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      abort = !slrd_n;
    end
    abort = 0;
    // R3: empty glitch shorter than sync depth timing, then real empty
    wait_cyc(7);
    empty_n = 0; wait_cyc(1); empty_n = 1; wait_cyc(25);
    empty_n = 0; wait_cyc(25);
    chk(preab == 1, "R4", preab, 1);
    abort = 1; @(negedge clk); abort = 0;
    empty_n = 1; full_n = 1;
    wait_cyc(40);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule